// File: doc/BRIEF.md
# Adder Self-Test with Signature Compression

This block is a built-in self-test wrapper around a 4-bit ripple-carry adder. When started, it seeds a 9-bit pseudorandom generator. The generator then steps through its full period. On every step it supplies both 4-bit operands and the carry-in of the adder. The adder's five result bits (four sum bits and the carry-out) are folded into a 4-bit signature register on every clock of the run. The final 4-bit word is held on the output pins, for example to drive indicator lights. A pass flag compares that word against a constant golden signature.

A four-state one-hot controller sequences the test through these phases:
- Idle
- Seed
- Run
- Done

The idle flip-flop holds the inverted state, so a cleared register means Idle. The Done state actively clears the Seed and Run flip-flops, which makes the controller recover when one of them is set together with Done. Software-free use is intended: pulse `start`, wait for `done`, read `pass`.

Top module: `adder_bist`

## Requirements
- R1: While `rst_n` is low and after its release, `done` and `pass` are 0 and `signature` is 4'h0; the controller is in Idle.
- R2: A `start` sampled high in Idle moves to Seed on that edge. The next edge moves to Run. Run lasts exactly 511 clocks. `done` rises on the 513th rising edge, counting the edge that sampled `start`.
- R3: Seed loads the generator with the SEED parameter (default 9'h1FF). On each Run clock the generator shifts toward its top bit and enters `g[8] ^ g[3]` at bit 0, giving a period of 511.
- R4: Operand A is generator bits [3:0], operand B is bits [7:4], and carry-in is bit 8. A ripple-carry adder forms the 4 sum bits and the carry-out.
- R5: Seed clears the signature to 0. On each Run clock the signature becomes `{s[2:0], s[3]^s[0]} ^ {sum[3], sum[2], sum[1], sum[0]^cout}`, computed from the adder result of that clock.
- R6: The signature does not change outside Run and Seed; in Done it stays frozen at the result of all 511 compressions.
- R7: `pass` is 1 exactly when `done` is 1 and `signature` equals the EXP_SIG parameter.
- R8: A `start` sampled high in Done returns to Idle (clearing `done`). A later run from the same seed reproduces the same signature.
- R9: `start` has no effect during Seed and Run. The run length and the signature are unchanged by it.
- R10: Exactly one state is active at any time, and Done forces the Seed and Run flip-flops clear on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a test from Idle; return to Idle from Done |
| signature | output | 4 | Current signature register contents |
| done | output | 1 | High while the controller is in Done |
| pass | output | 1 | High in Done when the signature equals EXP_SIG |

## Verification
Two events share one edge. On the final Run clock, the 511th compression updates the signature on the same edge that sets `done`. The bench's reference model must therefore see the last adder result folded in exactly when `done` is first observed high; comparing signature, `done` and `pass` on every clock judges this edge directly. The other coincidence is `start` held high while Done is entered: the return to Idle and the following restart fall on consecutive edges. This is provoked by holding `start` through a whole run and by pulsing it during Seed and Run, where it must be ignored. Sixteen extra instances, each with a different EXP_SIG, confirm that exactly one of them raises `pass`.

// File: rtl/adder_bist.sv
module adder_bist #(
  parameter int             OP_W     = 4,
  parameter int             GEN_TAP  = 3,
  parameter logic [8:0]     SEED     = 9'h1FF,
  parameter logic [3:0]     EXP_SIG  = 4'h0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic [OP_W-1:0] signature,
  output logic            done,
  output logic            pass
);

  localparam int GEN_W   = 2 * OP_W + 1;
  localparam int SIG_W   = OP_W;
  localparam int RUN_LEN = (1 << GEN_W) - 1;
  localparam logic [GEN_W-1:0] LAST_CNT = GEN_W'(RUN_LEN - 1);

  // one-hot controller; idle is stored inverted so a cleared flop means Idle
  logic idle_n_q, seed_q, run_q, done_q;
  logic idle;
  assign idle = ~idle_n_q;

  logic [GEN_W-1:0] gen_q, cnt_q;
  logic [SIG_W-1:0] sig_q;
  logic             last;
  assign last = (cnt_q == LAST_CNT);

  // ripple-carry adder fed by the generator
  logic [OP_W-1:0] op_a, op_b, sum;
  logic [OP_W:0]   carry;
  assign op_a     = gen_q[OP_W-1:0];
  assign op_b     = gen_q[2*OP_W-1:OP_W];
  assign carry[0] = gen_q[GEN_W-1];

  for (genvar i = 0; i < OP_W; i++) begin : g_fa
    assign sum[i]     = op_a[i] ^ op_b[i] ^ carry[i];
    assign carry[i+1] = (op_a[i] & op_b[i]) | (carry[i] & (op_a[i] ^ op_b[i]));
  end

  logic [SIG_W-1:0] sig_in, sig_shift;
  assign sig_in    = sum ^ {{(SIG_W-1){1'b0}}, carry[OP_W]};
  assign sig_shift = {sig_q[SIG_W-2:0], sig_q[SIG_W-1] ^ sig_q[0]};

  logic idle_nxt, seed_nxt, run_nxt, done_nxt;
  assign idle_nxt = (idle & ~start) | (done_q & start);
  assign seed_nxt = idle & start & ~done_q;
  assign run_nxt  = ~done_q & (seed_q | (run_q & ~last));
  assign done_nxt = (run_q & last) | (done_q & ~start);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_n_q <= 1'b0;
      seed_q   <= 1'b0;
      run_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      idle_n_q <= ~idle_nxt;
      seed_q   <= seed_nxt;
      run_q    <= run_nxt;
      done_q   <= done_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q <= '0;
      cnt_q <= '0;
      sig_q <= '0;
    end else if (seed_q) begin
      gen_q <= SEED[GEN_W-1:0];
      cnt_q <= '0;
      sig_q <= '0;
    end else if (run_q) begin
      gen_q <= {gen_q[GEN_W-2:0], gen_q[GEN_W-1] ^ gen_q[GEN_TAP]};
      cnt_q <= cnt_q + 1'b1;
      sig_q <= sig_shift ^ sig_in;
    end
  end

  assign signature = sig_q;
  assign done      = done_q;
  assign pass      = done_q & (sig_q == EXP_SIG[SIG_W-1:0]);

  assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({idle, seed_q, run_q, done_q}) == 1);

  assert_done_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> (!seed_q && !run_q));

  assert_seed_to_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seed_q |=> (run_q && cnt_q == '0 && sig_q == '0));

  assert_run_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !last) |=> run_q);

  assert_gen_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (gen_q != '0));

  assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q || idle) |=> $stable(sig_q));

  assert_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done_q);

endmodule

// File: tb/adder_bist_bench.sv
`timescale 1ns/1ps
module adder_bist_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] signature;
  logic done, pass;
  logic [15:0] pass_vec;

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  adder_bist u_adder_bist (.clk(clk), .rst_n(rst_n), .start(start),
                           .signature(signature), .done(done), .pass(pass));

  for (genvar i = 0; i < 16; i++) begin : g_exp
    logic [3:0] s_unused;
    logic       d_unused;
    adder_bist #(.EXP_SIG(4'(i))) u_exp (.clk(clk), .rst_n(rst_n), .start(start),
                                        .signature(s_unused), .done(d_unused),
                                        .pass(pass_vec[i]));
  end

  // behavioural reference: 0 idle, 1 seed, 2 run, 3 done
  int         m_st;
  logic [8:0] m_gen;
  logic [3:0] m_sig;
  int         m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_sig = 4'h0; m_gen = 9'h0; m_cnt = 0;
    end else begin
      case (m_st)
        0: if (start) m_st = 1;
        1: begin m_gen = 9'h1FF; m_sig = 4'h0; m_cnt = 0; m_st = 2; end
        2: begin
          int a, b, ci, r;
          logic [3:0] d;
          a  = int'(m_gen[3:0]);
          b  = int'(m_gen[7:4]);
          ci = int'(m_gen[8]);
          r  = a + b + ci;
          d  = 4'(r) ^ {3'b000, (r >= 16)};
          m_sig = {m_sig[2:0], m_sig[3] ^ m_sig[0]} ^ d;
          m_gen = {m_gen[7:0], m_gen[8] ^ m_gen[3]};
          if (m_cnt == 510) m_st = 3;
          m_cnt++;
        end
        default: if (start) m_st = 0;
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare against the model every clock, away from the active edge
  always @(negedge clk) if (rst_n) begin
    bit m_done;
    m_done = (m_st == 3);
    chk(signature == m_sig, "R3/R4/R5 signature", int'(signature), int'(m_sig));
    chk(done == m_done, "R2 done", int'(done), int'(m_done));
    chk(pass == (m_done && m_sig == 4'h0), "R7 pass", int'(pass),
        int'(m_done && m_sig == 4'h0));
    for (int i = 0; i < 16; i++) begin
      bit e;
      e = m_done && (m_sig == 4'(i));
      chk(pass_vec[i] == e, "R7 pass array", int'(pass_vec[i]), int'(e));
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic run_and_time(input string req, output logic [3:0] fin);
    int k = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) begin start = 1'b0; k = 1; end
    while (!done && k < 600) begin @(negedge clk); k++; end
    chk(k == 513, req, k, 513);
    fin = signature;
  endtask

  logic [3:0] sig1, sig2;

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !pass && signature == 4'h0, "R1 in reset", {signature, done, pass}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!done && !pass && signature == 4'h0, "R1 after reset", {signature, done, pass}, 0);

    run_and_time("R2 start-to-done latency", sig1);
    repeat (40) @(negedge clk);
    chk(signature == sig1 && done, "R6 frozen in done", int'(signature), int'(sig1));

    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(!done, "R8 start in done returns to idle", int'(done), 0);
    repeat (30) @(negedge clk);
    chk(signature == sig1 && !done, "R6 frozen in idle", int'(signature), int'(sig1));

    // second run with start pulsed during Seed and Run
    fork
      run_and_time("R9 latency with start noise", sig2);
      begin
        @(negedge clk); @(negedge clk);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (100) @(negedge clk);
        start = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
      end
    join
    chk(sig2 == sig1, "R8/R9 repeat signature", int'(sig2), int'(sig1));

    // start held high across Done: back to Idle, then rerun on the next edge
    @(negedge clk) start = 1'b1;
    repeat (1100) @(negedge clk);
    start = 1'b0;
    repeat (600) @(negedge clk);
    chk(done && signature == sig1, "R8/R10 held start", int'(signature), int'(sig1));

    // reset in the middle of a run
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (200) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!done && !pass && signature == 4'h0, "R1 mid-run reset", {signature, done, pass}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!done && signature == 4'h0, "R1 idle after mid-run reset", int'(signature), 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule